// File: doc/BRIEF.md
# Timed Signed Divider (32 by 16)

The block divides a 32-bit two's-complement dividend by a 16-bit two's-complement divisor, one quotient bit per clock, and returns a packed word with the remainder in bits 31:16 and the quotient in bits 15:0. Along with the result it reports the four condition flags (negative, zero, overflow, carry) and the number of bus cycles a legacy microcoded CPU would have spent on the same operands. That count depends on the data: each quotient bit costs differently depending on whether its trial subtraction succeeded, and each combination of operand signs adds its own surcharge.

A caller pulses `start_i` with the operands while `busy_o` is low and waits for the one-cycle `done_o` pulse. The outputs then hold until the next accepted start. Two cases finish in one cycle. A zero divisor is reported on `dbz_o` so that an outside exception unit can act on it. A quotient that clearly cannot fit triggers an early overflow exit. In both cases, and in any other overflow, the packed result is the original dividend, so the destination register is left as it was.

Top module: `sdiv_timed`

## Requirements
- R1: After reset `busy_o`, `done_o` and `dbz_o` are 0, and `result_o`, all four flags and `cycles_o` are 0.
- R2: A start taken while idle with a nonzero divisor and no early overflow raises `busy_o` in the next cycle. `done_o` pulses 18 clock edges after the start edge, and `busy_o` is low while `done_o` is high.
- R3: If the divisor's magnitude shifted left by 16 is less than or equal to the dividend's magnitude, `done_o` pulses one edge after start with V=1, N=1, Z=0, C=0, `result_o` equal to the dividend and `cycles_o`=16.
- R4: On success `result_o[15:0]` is the quotient truncated toward zero and `result_o[31:16]` is the remainder, which carries the dividend's sign.
- R5: On success N equals quotient bit 15, Z is 1 exactly when the quotient is 0, and V and C are 0.
- R6: On a full division `cycles_o` = 12, plus 2 if the dividend is negative, plus 6 for each 1 and 8 for each 0 among quotient-magnitude bits 15 down to 1, plus 4, plus 16 if the divisor is negative, else 18 if only the dividend is negative, else 14.
- R7: A full division whose signed quotient lies outside -32768..32767 ends with V=1, N=1, Z=0, C=0, `result_o` equal to the dividend and `cycles_o` as in R6.
- R8: A zero divisor sets `dbz_o` and pulses `done_o` one edge after start. `result_o` equals the dividend, `cycles_o` is 0 and the flags keep their previous values. `dbz_o` stays high until the next accepted start.
- R9: A start pulse while `busy_o` is high is ignored: the running division finishes with its own result and timing.
- R10: While idle and with no start, `result_o`, the flags, `cycles_o` and `dbz_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when idle |
| dividend_i | input | 32 | Signed dividend |
| divisor_i | input | 16 | Signed divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dbz_o | output | 1 | Last accepted divisor was zero |
| result_o | output | 32 | Remainder in 31:16, quotient in 15:0, or the dividend on overflow or zero divisor |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |
| cycles_o | output | 8 | Bus cycles charged for the operation |

## Verification
The checker watches every cycle for the zero-divisor response and its copied dividend, the overflow flag pattern, the flag relations of a successful quotient, the legal range of the cycle count, and the outputs holding still while idle. Exact quotient and remainder values, the per-bit cycle sum, the 18-edge latency, the dropped start during a run and the flags surviving a zero divisor all need the bench's scenarios. In those scenarios a reference model built on integer division predicts every field.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_STEP, ST_FIX} sdiv_state_e;

  localparam int unsigned CYC_BASE      = 12;
  localparam int unsigned CYC_DVD_NEG   = 2;
  localparam int unsigned CYC_EARLY     = 16;
  localparam int unsigned CYC_BIT_HIT   = 6;
  localparam int unsigned CYC_BIT_MISS  = 8;
  localparam int unsigned CYC_LAST      = 4;
  localparam int unsigned CYC_DSR_NEG   = 16;
  localparam int unsigned CYC_ONLY_DVD  = 18;
  localparam int unsigned CYC_BOTH_POS  = 14;
endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep #(
  parameter int unsigned DSR_W = 16,
  localparam int unsigned DVD_W = 2 * DSR_W
) (
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DSR_W-1:0] divisor_i,
  output logic [DVD_W-1:0] dvd_abs_o,
  output logic [DVD_W-1:0] dsr_abs_o,
  output logic             dvd_neg_o,
  output logic             dsr_neg_o,
  output logic             dsr_zero_o,
  output logic             early_ovf_o
);
  logic [DSR_W-1:0] dsr_mag;

  assign dvd_neg_o   = dividend_i[DVD_W-1];
  assign dsr_neg_o   = divisor_i[DSR_W-1];
  assign dsr_zero_o  = (divisor_i == '0);
  assign dvd_abs_o   = dvd_neg_o ? (~dividend_i + 1'b1) : dividend_i;
  assign dsr_mag     = dsr_neg_o ? (~divisor_i + 1'b1) : divisor_i;
  // divisor sits in the upper half; a fit test against the full dividend
  assign dsr_abs_o   = {dsr_mag, {DSR_W{1'b0}}};
  assign early_ovf_o = (dsr_abs_o <= dvd_abs_o);
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step import sdiv_pkg::*; #(
  parameter int unsigned DSR_W = 16,
  parameter int unsigned CYC_W = 8,
  localparam int unsigned DVD_W = 2 * DSR_W
) (
  input  logic [DVD_W-1:0] rem_i,
  input  logic [DVD_W-1:0] dsr_i,
  input  logic             last_i,
  output logic [DVD_W-1:0] rem_o,
  output logic             bit_o,
  output logic [CYC_W-1:0] cost_o
);
  logic [DVD_W-1:0] shifted;

  // rem_i < dsr_i <= 2^(DVD_W-1), so the shift never loses a set bit
  assign shifted = {rem_i[DVD_W-2:0], 1'b0};
  assign bit_o   = (shifted >= dsr_i);
  assign rem_o   = bit_o ? (shifted - dsr_i) : shifted;

  always_comb begin
    if (last_i)     cost_o = CYC_W'(CYC_LAST);
    else if (bit_o) cost_o = CYC_W'(CYC_BIT_HIT);
    else            cost_o = CYC_W'(CYC_BIT_MISS);
  end
endmodule

// File: rtl/sdiv_fixup.sv
module sdiv_fixup import sdiv_pkg::*; #(
  parameter int unsigned DSR_W = 16,
  parameter int unsigned CYC_W = 8
) (
  input  logic [DSR_W-1:0] quo_i,
  input  logic [DSR_W-1:0] rem_i,
  input  logic             dvd_neg_i,
  input  logic             dsr_neg_i,
  output logic [DSR_W-1:0] quo_o,
  output logic [DSR_W-1:0] rem_o,
  output logic             ovf_o,
  output logic [CYC_W-1:0] cost_o
);
  logic [DSR_W-1:0] quo_neg, rem_neg;
  logic             neg_bad;

  assign quo_neg = ~quo_i + 1'b1;
  assign rem_neg = ~rem_i + 1'b1;
  // a negated quotient must land on a negative value or zero
  assign neg_bad = (quo_neg != '0) && !quo_neg[DSR_W-1];

  always_comb begin
    quo_o = quo_i;
    rem_o = rem_i;
    ovf_o = 1'b0;
    if (dsr_neg_i) begin
      cost_o = CYC_W'(CYC_DSR_NEG);
      if (dvd_neg_i) begin
        ovf_o = quo_i[DSR_W-1];
        rem_o = rem_neg;
      end else begin
        quo_o = quo_neg;
        ovf_o = neg_bad;
      end
    end else if (dvd_neg_i) begin
      cost_o = CYC_W'(CYC_ONLY_DVD);
      quo_o  = quo_neg;
      ovf_o  = neg_bad;
      rem_o  = rem_neg;
    end else begin
      cost_o = CYC_W'(CYC_BOTH_POS);
      ovf_o  = quo_i[DSR_W-1];
    end
  end
endmodule

// File: rtl/sdiv_timed.sv
module sdiv_timed import sdiv_pkg::*; #(
  parameter int unsigned DSR_W = 16,
  parameter int unsigned CYC_W = 8,
  localparam int unsigned DVD_W  = 2 * DSR_W,
  localparam int unsigned STEP_W = $clog2(DSR_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DSR_W-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             dbz_o,
  output logic [DVD_W-1:0] result_o,
  output logic             flag_n_o,
  output logic             flag_z_o,
  output logic             flag_v_o,
  output logic             flag_c_o,
  output logic [CYC_W-1:0] cycles_o
);
  sdiv_state_e      state_q;
  logic [STEP_W-1:0] step_q;
  logic [DVD_W-1:0] rem_q, dsr_q, dvd_q;
  logic [DSR_W-1:0] quo_q;
  logic [CYC_W-1:0] acc_q;
  logic             dvd_neg_q, dsr_neg_q;

  logic [DVD_W-1:0] p_dvd_abs, p_dsr_abs;
  logic             p_dvd_neg, p_dsr_neg, p_zero, p_early;
  logic [DVD_W-1:0] s_rem;
  logic             s_bit, s_last;
  logic [CYC_W-1:0] s_cost;
  logic [DSR_W-1:0] f_quo, f_rem;
  logic             f_ovf;
  logic [CYC_W-1:0] f_cost;
  logic             accept;

  sdiv_prep #(.DSR_W(DSR_W)) i_prep (
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .dvd_abs_o  (p_dvd_abs),
    .dsr_abs_o  (p_dsr_abs),
    .dvd_neg_o  (p_dvd_neg),
    .dsr_neg_o  (p_dsr_neg),
    .dsr_zero_o (p_zero),
    .early_ovf_o(p_early)
  );

  assign s_last = (step_q == STEP_W'(DSR_W - 1));

  sdiv_step #(.DSR_W(DSR_W), .CYC_W(CYC_W)) i_step (
    .rem_i (rem_q),
    .dsr_i (dsr_q),
    .last_i(s_last),
    .rem_o (s_rem),
    .bit_o (s_bit),
    .cost_o(s_cost)
  );

  sdiv_fixup #(.DSR_W(DSR_W), .CYC_W(CYC_W)) i_fix (
    .quo_i    (quo_q),
    .rem_i    (rem_q[DVD_W-1:DSR_W]),
    .dvd_neg_i(dvd_neg_q),
    .dsr_neg_i(dsr_neg_q),
    .quo_o    (f_quo),
    .rem_o    (f_rem),
    .ovf_o    (f_ovf),
    .cost_o   (f_cost)
  );

  assign accept = start_i && (state_q == ST_IDLE);
  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      step_q    <= '0;
      rem_q     <= '0;
      dsr_q     <= '0;
      dvd_q     <= '0;
      quo_q     <= '0;
      acc_q     <= '0;
      dvd_neg_q <= 1'b0;
      dsr_neg_q <= 1'b0;
      done_o    <= 1'b0;
      dbz_o     <= 1'b0;
      result_o  <= '0;
      flag_n_o  <= 1'b0;
      flag_z_o  <= 1'b0;
      flag_v_o  <= 1'b0;
      flag_c_o  <= 1'b0;
      cycles_o  <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          dbz_o <= p_zero;
          if (p_zero) begin
            // flags untouched: the exception unit owns this case
            done_o   <= 1'b1;
            result_o <= dividend_i;
            cycles_o <= '0;
          end else if (p_early) begin
            done_o   <= 1'b1;
            result_o <= dividend_i;
            flag_n_o <= 1'b1;
            flag_z_o <= 1'b0;
            flag_v_o <= 1'b1;
            flag_c_o <= 1'b0;
            cycles_o <= CYC_W'(CYC_EARLY);
          end else begin
            state_q   <= ST_STEP;
            step_q    <= '0;
            rem_q     <= p_dvd_abs;
            dsr_q     <= p_dsr_abs;
            dvd_q     <= dividend_i;
            quo_q     <= '0;
            dvd_neg_q <= p_dvd_neg;
            dsr_neg_q <= p_dsr_neg;
            acc_q     <= p_dvd_neg ? CYC_W'(CYC_BASE + CYC_DVD_NEG) : CYC_W'(CYC_BASE);
          end
        end
        ST_STEP: begin
          rem_q  <= s_rem;
          quo_q  <= {quo_q[DSR_W-2:0], s_bit};
          acc_q  <= acc_q + s_cost;
          step_q <= step_q + 1'b1;
          if (s_last) state_q <= ST_FIX;
        end
        ST_FIX: begin
          state_q  <= ST_IDLE;
          done_o   <= 1'b1;
          cycles_o <= acc_q + f_cost;
          flag_c_o <= 1'b0;
          flag_v_o <= f_ovf;
          if (f_ovf) begin
            result_o <= dvd_q;
            flag_n_o <= 1'b1;
            flag_z_o <= 1'b0;
          end else begin
            result_o <= {f_rem, f_quo};
            flag_n_o <= f_quo[DSR_W-1];
            flag_z_o <= (f_quo == '0);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdiv_timed_chk.sv
module sdiv_timed_chk #(
  parameter int unsigned DSR_W = 16,
  parameter int unsigned CYC_W = 8,
  localparam int unsigned DVD_W = 2 * DSR_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [DVD_W-1:0] dividend_i,
  input logic [DSR_W-1:0] divisor_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             dbz_o,
  input logic [DVD_W-1:0] result_o,
  input logic             flag_n_o,
  input logic             flag_z_o,
  input logic             flag_v_o,
  input logic             flag_c_o,
  input logic [CYC_W-1:0] cycles_o
);
  a_r8_zero_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && (divisor_i == '0) |=>
      dbz_o && done_o && (result_o == $past(dividend_i)) && (cycles_o == '0));

  a_r2_start_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o || done_o);

  a_r2_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r7_ovf_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && flag_v_o && !dbz_o |-> flag_n_o && !flag_z_o && !flag_c_o);

  a_r5_success_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !flag_v_o && !dbz_o |->
      (flag_n_o == result_o[DSR_W-1]) && (flag_z_o == (result_o[DSR_W-1:0] == '0)) && !flag_c_o);

  a_r6_cycle_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !flag_v_o && !dbz_o |-> (cycles_o >= CYC_W'(120)) && (cycles_o <= CYC_W'(156)));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=>
      $stable(result_o) && $stable(cycles_o) && $stable(dbz_o) &&
      $stable({flag_n_o, flag_z_o, flag_v_o, flag_c_o}));
endmodule

bind sdiv_timed sdiv_timed_chk #(.DSR_W(DSR_W), .CYC_W(CYC_W)) i_chk (.*);

// File: tb/test_sdiv_timed.sv
module test_sdiv_timed;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] dividend_i = '0;
  logic [15:0] divisor_i = '0;
  logic        busy_o, done_o, dbz_o;
  logic [31:0] result_o;
  logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o;
  logic [7:0]  cycles_o;

  int checks = 0;
  int fails = 0;
  logic [3:0] flg_m = 4'b0000;  // {N,Z,V,C} model state

  always #2 clk_i = ~clk_i;

  sdiv_timed i_sdiv_timed (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // expected outcome from integer arithmetic
  task automatic model(input logic [31:0] dvd, input logic [15:0] dsr,
                       output logic [31:0] res, output int cyc, output int lat,
                       output bit dbz, output string req);
    longint sd, sv, ad, av, aq, ar, q, r;
    int ones;
    sd = longint'($signed(dvd));
    sv = longint'($signed(dsr));
    ad = sd < 0 ? -sd : sd;
    av = sv < 0 ? -sv : sv;
    dbz = 1'b0;
    if (sv == 0) begin  // R8
      dbz = 1'b1; res = dvd; cyc = 0; lat = 1; req = "R8";
      return;
    end
    if ((av << 16) <= ad) begin  // R3
      res = dvd; cyc = 16; lat = 1; flg_m = 4'b1010; req = "R3";
      return;
    end
    aq = ad / av;
    ar = ad % av;
    ones = 0;
    for (int b = 1; b < 16; b++) ones += int'((aq >> b) & 1);
    cyc = 12 + (sd < 0 ? 2 : 0) + 6 * ones + 8 * (15 - ones) + 4;
    if (sv < 0) cyc += 16;
    else if (sd < 0) cyc += 18;
    else cyc += 14;
    lat = 18;
    q = ((sd < 0) != (sv < 0)) ? -aq : aq;
    r = (sd < 0) ? -ar : ar;
    if (q > 32767 || q < -32768) begin  // R7
      res = dvd; flg_m = 4'b1010; req = "R7";
    end else begin
      res = {r[15:0], q[15:0]};
      flg_m = {q[15] == 1'b1, q[15:0] == 16'h0, 1'b0, 1'b0};
      req = "R4";
    end
  endtask

  task automatic run_op(input logic [31:0] dvd, input logic [15:0] dsr,
                        input bit poke_busy);
    logic [31:0] eres;
    int ecyc, elat, lat;
    bit edbz;
    string req;
    model(dvd, dsr, eres, ecyc, elat, edbz, req);
    @(negedge clk_i);
    start_i = 1'b1; dividend_i = dvd; divisor_i = dsr;
    lat = 0;
    do begin
      @(negedge clk_i);
      start_i = 1'b0;
      lat++;
      if (poke_busy && lat == 5) begin  // R9 stray start mid-run
        start_i = 1'b1; dividend_i = 32'h0000_0009; divisor_i = 16'h0003;
      end
      if (poke_busy && lat == 6) begin
        chk(busy_o == 1'b1, "R9", "busy after stray start", busy_o, 1);
      end
    end while (!done_o && lat < 40);
    chk(lat == elat, elat == 1 ? req : "R2", "latency", lat, elat);
    chk(result_o == eres, req, "result", result_o, eres);
    chk({flag_n_o, flag_z_o, flag_v_o, flag_c_o} == flg_m, req == "R4" ? "R5" : req,
        "flags", {flag_n_o, flag_z_o, flag_v_o, flag_c_o}, flg_m);
    chk(int'(cycles_o) == ecyc, edbz ? "R8" : "R6", "cycles", cycles_o, ecyc);
    chk(dbz_o == edbz, "R8", "dbz", dbz_o, edbz);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] hold_res;
    logic [7:0]  hold_cyc;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk({busy_o, done_o, dbz_o} == 3'b000, "R1", "status", {busy_o, done_o, dbz_o}, 0);
    chk(result_o == '0 && cycles_o == '0, "R1", "result/cycles", result_o, 0);
    chk({flag_n_o, flag_z_o, flag_v_o, flag_c_o} == 4'b0, "R1", "flags",
        {flag_n_o, flag_z_o, flag_v_o, flag_c_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_op(32'd100, 16'd7, 1'b0);            // R4 both positive
    run_op(-32'sd100, 16'd7, 1'b0);          // R6 dividend negative
    run_op(32'd100, -16'sd7, 1'b0);          // divisor negative
    run_op(-32'sd100, -16'sd7, 1'b0);        // both negative
    run_op(32'd0, 16'd5, 1'b0);              // R5 zero quotient
    run_op(32'h0000_8000, 16'd1, 1'b0);      // R7 late overflow, positive
    run_op(32'hFFFF_8000, 16'd1, 1'b0);      // -32768 fits
    run_op(32'h0000_8000, 16'hFFFF, 1'b0);   // -32768 via negative divisor
    run_op(32'hFFFF_7FFF, 16'd1, 1'b0);      // R7 late overflow, negative
    run_op(32'h8000_0000, 16'h8000, 1'b0);   // R3 extreme magnitudes
    run_op(32'h0012_3456, 16'h0012, 1'b0);   // R3 early exit
    run_op(32'd1000, 16'd3, 1'b0);           // set flags before zero divisor
    run_op(32'hDEAD_BEEF, 16'h0000, 1'b0);   // R8 flags kept
    run_op(32'd77777, 16'd311, 1'b1);        // R9 stray start ignored
    // R10 outputs hold while idle
    hold_res = result_o; hold_cyc = cycles_o;
    repeat (5) @(negedge clk_i);
    chk(result_o == hold_res && cycles_o == hold_cyc && !done_o, "R10", "idle hold",
        result_o, hold_res);
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d, r;
      logic [15:0] s;
      r = $urandom;
      case ($urandom % 4)
        0: d = $urandom;
        1: d = {{12{r[19]}}, r[19:0]};
        2: d = {{16{r[15]}}, r[15:0]};
        default: d = {{4{r[27]}}, r[27:0]};
      endcase
      s = ($urandom % 20 == 0) ? 16'h0 : (($urandom % 2) ? 16'($urandom) : {{8{r[31]}}, r[31:24]});
      run_op(d, s, 1'b0);
    end
    finish_run();
  end
endmodule